// File: doc/BRIEF.md
# Serial Channel Event Flags and Interrupt Request

This block collects single-cycle event pulses from one asynchronous serial channel and turns them into sticky software-visible flags and a single interrupt request line. Three factor flags record a finished transmit shift, a received byte moved into the receive buffer, and a receive error. The receive error flag gathers parity, framing and overrun faults. A separate sticky flag remembers framing faults in particular, meaning a stop bit that was sampled low.

Software reaches the block through a small register port with a 2-bit address and 4-bit data. It reads the flags and clears them by writing 1 to the bits it wants cleared. It also sets a three-bit enable mask. The request output rises when an enabled flag is set while the CPU global interrupt enable input is high. The request stays high until software clears the flag, so an interrupt handler must clear the flag before it re-enables interrupts.

Top module: `sio_event_flags`

## Requirements
- R1: After reset, the factor flags, the enable mask, the framing flag and `irq_req` are all 0.
- R2: A pulse sets factor bit0 on `ev_rx_ready`, factor bit1 on `ev_tx_done`, and factor bit2 on any of `ev_parity_err`, `ev_frame_err` or `ev_overrun_err`. This happens whatever the mask holds and whatever `rx_enable` holds. The flag is readable at address 0 after the next clock edge.
- R3: A write to address 0 clears each factor bit whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R4: If a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set. This holds for the factor flags and for the framing flag.
- R5: Address 1 holds the enable mask in bits [2:0]. The mask is written and read back there, and bit n enables factor bit n.
- R6: The framing flag reads at address 2, bit2. An `ev_frame_err` pulse sets it while `rx_enable` is 1. Writing 1 to bit2 of address 2 clears it.
- R7: While `rx_enable` is 0, the framing flag is cleared at the next edge and stays 0, even if `ev_frame_err` pulses.
- R8: `irq_req` is registered. It becomes 1 one clock after some factor bit, its mask bit and `cpu_ie` are all 1. It stays 1 while that condition holds, and it falls one clock after the condition ends.
- R9: Read bits with no flag behind them (address 0 and 1 bit3, address 2 bits 3, 1 and 0) read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx_ready | input | 1 | Pulse: received data placed in the buffer |
| ev_tx_done | input | 1 | Pulse: transmit shift register emptied |
| ev_parity_err | input | 1 | Pulse: parity fault on receive |
| ev_frame_err | input | 1 | Pulse: stop bit sampled low |
| ev_overrun_err | input | 1 | Pulse: receive overrun |
| rx_enable | input | 1 | Receiver enabled; 0 holds the framing flag clear |
| cpu_ie | input | 1 | CPU global interrupt enable |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` (combinational) |
| irq_req | output | 1 | Registered interrupt request |

## Verification
Two functions can act on one flag in the same cycle: the hardware set from an event pulse and the software write-1 clear. The bench provokes this by asserting `ev_rx_ready` in the very cycle that a write of 1 to address 0 bit0 is presented. It does the same with `ev_frame_err` against a write of 1 to address 2 bit2. After the edge it reads the register back and expects the flag to be set. A second collision pairs a clear of a flag that drives the request with that request's registered output. The bench expects `irq_req` to stay high for exactly one more cycle and then drop.

// File: rtl/sio_flags_pkg.sv
// Package: shared widths, register addresses and bit positions for the
// serial channel event flag block. Assumes a 2-bit address, 4-bit data port.
package sio_flags_pkg;
    localparam int unsigned NUM_FACTORS = 3;
    localparam int unsigned DATA_W      = 4;
    localparam int unsigned ADDR_W      = 2;

    localparam logic [ADDR_W-1:0] ADDR_FACTOR = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int unsigned IDX_RX_DONE = 0;
    localparam int unsigned IDX_TX_DONE = 1;
    localparam int unsigned IDX_RX_ERR  = 2;
    localparam int unsigned FRAME_BIT   = 2;
endpackage

// File: rtl/sio_sticky_bank.sv
// Module: bank of sticky bits. Each bit is set by a pulse, cleared by a
// write-1 strobe (set has priority), and forced to 0 while its hold input
// is high (hold has priority over everything). Synchronous active-low reset.
module sio_sticky_bank #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] hold_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Purpose: update one sticky bit with hold > set > clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n || hold_i[i]) begin
                q_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                q_o[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sio_reg_port.sv
// Module: register port. Decodes writes into clear strobes and the mask
// register, and multiplexes read data. Assumes single-cycle write strobes.
module sio_reg_port
    import sio_flags_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   we_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [NUM_FACTORS-1:0] factor_i,
    input  logic                   frame_i,
    output logic [NUM_FACTORS-1:0] factor_clr_o,
    output logic                   frame_clr_o,
    output logic [NUM_FACTORS-1:0] mask_o,
    output logic [DATA_W-1:0]      rdata_o
);
    localparam int unsigned PAD_W = DATA_W - NUM_FACTORS;

    // Purpose: hold the interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (we_i && addr_i == ADDR_MASK) begin
            mask_o <= wdata_i[NUM_FACTORS-1:0];
        end
    end

    // Purpose: turn write-1 data into clear strobes for the flag banks.
    always_comb begin
        factor_clr_o = '0;
        frame_clr_o  = 1'b0;
        if (we_i && addr_i == ADDR_FACTOR) begin
            factor_clr_o = wdata_i[NUM_FACTORS-1:0];
        end
        if (we_i && addr_i == ADDR_STATUS) begin
            frame_clr_o = wdata_i[FRAME_BIT];
        end
    end

    // Purpose: select the read data for the current address.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_FACTOR: rdata_o = {{PAD_W{1'b0}}, factor_i};
            ADDR_MASK:   rdata_o = {{PAD_W{1'b0}}, mask_o};
            ADDR_STATUS: rdata_o[FRAME_BIT] = frame_i;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/sio_irq_gen.sv
// Module: registered interrupt request. Raises the request one clock after
// any enabled flag is set while the CPU global enable is high.
module sio_irq_gen #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags_i,
    input  logic [WIDTH-1:0] mask_i,
    input  logic             cpu_ie_i,
    output logic             irq_o
);
    // Purpose: register the OR of enabled flags gated by the CPU enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= (|(flags_i & mask_i)) & cpu_ie_i;
        end
    end
endmodule

// File: rtl/sio_event_flags.sv
// Module: top of the serial channel event flag block. Combines event pulses
// into three factor flags and a framing flag, exposes them on a small
// register port, and drives one registered interrupt request.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module sio_event_flags
    import sio_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_rx_ready,
    input  logic              ev_tx_done,
    input  logic              ev_parity_err,
    input  logic              ev_frame_err,
    input  logic              ev_overrun_err,
    input  logic              rx_enable,
    input  logic              cpu_ie,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);
    logic [NUM_FACTORS-1:0] factor_set;
    logic [NUM_FACTORS-1:0] factor_clr;
    logic [NUM_FACTORS-1:0] factor_q;
    logic [NUM_FACTORS-1:0] mask_q;
    logic                   frame_clr;
    logic                   frame_q;

    // Purpose: map event pulses onto factor bit positions.
    always_comb begin
        factor_set              = '0;
        factor_set[IDX_RX_DONE] = ev_rx_ready;
        factor_set[IDX_TX_DONE] = ev_tx_done;
        factor_set[IDX_RX_ERR]  = ev_parity_err | ev_frame_err | ev_overrun_err;
    end

    sio_sticky_bank #(.WIDTH(NUM_FACTORS)) u_factor (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (factor_set),
        .clr_i  (factor_clr),
        .hold_i ({NUM_FACTORS{1'b0}}),
        .q_o    (factor_q)
    );

    sio_sticky_bank #(.WIDTH(1)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_frame_err),
        .clr_i  (frame_clr),
        .hold_i (~rx_enable),
        .q_o    (frame_q)
    );

    sio_reg_port u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (bus_addr),
        .we_i         (bus_we),
        .wdata_i      (bus_wdata),
        .factor_i     (factor_q),
        .frame_i      (frame_q),
        .factor_clr_o (factor_clr),
        .frame_clr_o  (frame_clr),
        .mask_o       (mask_q),
        .rdata_o      (bus_rdata)
    );

    sio_irq_gen #(.WIDTH(NUM_FACTORS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_i  (factor_q),
        .mask_i   (mask_q),
        .cpu_ie_i (cpu_ie),
        .irq_o    (irq_req)
    );
endmodule

// File: rtl/sio_event_flags_chk.sv
// Module: assertion checker for sio_event_flags, attached by bind.
module sio_event_flags_chk
    import sio_flags_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ev_rx_ready,
    input logic                   ev_tx_done,
    input logic                   ev_parity_err,
    input logic                   ev_frame_err,
    input logic                   ev_overrun_err,
    input logic                   rx_enable,
    input logic                   cpu_ie,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic                   irq_req,
    input logic [NUM_FACTORS-1:0] factor_q,
    input logic [NUM_FACTORS-1:0] mask_q,
    input logic                   frame_q
);
    // R2
    rx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ready |=> factor_q[IDX_RX_DONE]);
    // R2
    rx_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_parity_err || ev_frame_err || ev_overrun_err) |=> factor_q[IDX_RX_ERR]);
    // R3
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_FACTOR && bus_wdata[IDX_TX_DONE] && !ev_tx_done)
        |=> !factor_q[IDX_TX_DONE]);
    // R4
    tx_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_FACTOR && bus_wdata[IDX_TX_DONE] && ev_tx_done)
        |=> factor_q[IDX_TX_DONE]);
    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_MASK) |=> mask_q == $past(bus_wdata[NUM_FACTORS-1:0]));
    // R7
    rx_off_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !frame_q);
    // R8
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(cpu_ie));
    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(factor_q & mask_q) != '0));
endmodule

bind sio_event_flags sio_event_flags_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_rx_ready    (ev_rx_ready),
    .ev_tx_done     (ev_tx_done),
    .ev_parity_err  (ev_parity_err),
    .ev_frame_err   (ev_frame_err),
    .ev_overrun_err (ev_overrun_err),
    .rx_enable      (rx_enable),
    .cpu_ie         (cpu_ie),
    .bus_addr       (bus_addr),
    .bus_we         (bus_we),
    .bus_wdata      (bus_wdata),
    .irq_req        (irq_req),
    .factor_q       (factor_q),
    .mask_q         (mask_q),
    .frame_q        (frame_q)
);

// File: tb/tb_sio_event_flags.sv
// Directed bench for sio_event_flags: one task per scenario.
module tb_sio_event_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_rx_ready = 0, ev_tx_done = 0, ev_parity_err = 0;
    logic       ev_frame_err = 0, ev_overrun_err = 0;
    logic       rx_enable = 1'b1, cpu_ie = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       irq_req;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    sio_event_flags dut (
        .clk(clk), .rst_n(rst_n),
        .ev_rx_ready(ev_rx_ready), .ev_tx_done(ev_tx_done),
        .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
        .ev_overrun_err(ev_overrun_err), .rx_enable(rx_enable), .cpu_ie(cpu_ie),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // which: 0 rx_ready, 1 tx_done, 2 parity, 3 frame, 4 overrun
    task automatic pulse(input int which);
        case (which)
            0: ev_rx_ready = 1'b1;
            1: ev_tx_done = 1'b1;
            2: ev_parity_err = 1'b1;
            3: ev_frame_err = 1'b1;
            default: ev_overrun_err = 1'b1;
        endcase
        tick();
        {ev_rx_ready, ev_tx_done, ev_parity_err, ev_frame_err, ev_overrun_err} = '0;
    endtask

    task automatic t_reset();
        logic [3:0] d;
        rd(2'd0, d); chk("R1 factor", d, 4'h0);
        rd(2'd1, d); chk("R1 mask", d, 4'h0);
        rd(2'd2, d); chk("R1 frame", d, 4'h0);
        chk("R1 irq", {3'b0, irq_req}, 4'h0);
        rd(2'd3, d); chk("R9 addr3", d, 4'h0);
    endtask

    task automatic t_events();
        logic [3:0] d;
        pulse(0); rd(2'd0, d); chk("R2 rx_ready->bit0", d, 4'h1);
        tick(); chk("R8 masked no irq", {3'b0, irq_req}, 4'h0);
        pulse(1); rd(2'd0, d); chk("R2 tx_done->bit1", d, 4'h3);
        wr(2'd0, 4'h3); rd(2'd0, d); chk("R3 clear two", d, 4'h0);
        pulse(2); rd(2'd0, d); chk("R2 parity->bit2", d, 4'h4);
        wr(2'd0, 4'h4);
        pulse(4); rd(2'd0, d); chk("R2 overrun->bit2", d, 4'h4);
        wr(2'd0, 4'h4);
        pulse(3); rd(2'd0, d); chk("R2 frame->bit2", d, 4'h4);
        rd(2'd2, d); chk("R6 frame flag set", d, 4'h4);
        wr(2'd2, 4'h4); rd(2'd2, d); chk("R6 frame flag clear", d, 4'h0);
        wr(2'd0, 4'h4);
    endtask

    task automatic t_write_zero();
        logic [3:0] d;
        pulse(0); pulse(1); pulse(2);
        wr(2'd0, 4'h8); rd(2'd0, d); chk("R3 write0 no effect", d, 4'h7);
        wr(2'd0, 4'h2); rd(2'd0, d); chk("R3 clear bit1 only", d, 4'h5);
        wr(2'd0, 4'h7); rd(2'd0, d); chk("R3 all clear", d, 4'h0);
    endtask

    task automatic t_collide();
        logic [3:0] d;
        bus_addr = 2'd0; bus_wdata = 4'h1; bus_we = 1'b1; ev_rx_ready = 1'b1;
        tick();
        bus_we = 1'b0; ev_rx_ready = 1'b0;
        rd(2'd0, d); chk("R4 set beats clear", d, 4'h1);
        bus_addr = 2'd2; bus_wdata = 4'h4; bus_we = 1'b1; ev_frame_err = 1'b1;
        tick();
        bus_we = 1'b0; ev_frame_err = 1'b0;
        rd(2'd2, d); chk("R4 frame set beats clear", d, 4'h4);
        wr(2'd2, 4'h4); wr(2'd0, 4'h7);
    endtask

    task automatic t_mask();
        logic [3:0] d;
        wr(2'd1, 4'h5); rd(2'd1, d); chk("R5 mask readback", d, 4'h5);
        wr(2'd1, 4'hF); rd(2'd1, d); chk("R9 mask bit3 zero", d, 4'h7);
        wr(2'd1, 4'h0); rd(2'd1, d); chk("R5 mask cleared", d, 4'h0);
    endtask

    task automatic t_irq();
        cpu_ie = 1'b1;
        wr(2'd1, 4'h1);
        pulse(0);
        chk("R8 not yet", {3'b0, irq_req}, 4'h0);
        tick(); chk("R8 raised", {3'b0, irq_req}, 4'h1);
        tick(); tick(); chk("R8 held", {3'b0, irq_req}, 4'h1);
        wr(2'd0, 4'h1);
        chk("R8 one more cycle", {3'b0, irq_req}, 4'h1);
        tick(); chk("R8 dropped", {3'b0, irq_req}, 4'h0);
        pulse(1); tick(); tick();
        chk("R8 unmasked bit no irq", {3'b0, irq_req}, 4'h0);
        wr(2'd1, 4'h2); tick();
        chk("R5 mask enables bit1", {3'b0, irq_req}, 4'h1);
        cpu_ie = 1'b0; tick(); tick();
        chk("R8 cpu_ie low gates", {3'b0, irq_req}, 4'h0);
        wr(2'd0, 4'h7); wr(2'd1, 4'h0);
    endtask

    task automatic t_rx_off();
        logic [3:0] d;
        pulse(3);
        rx_enable = 1'b0; tick();
        rd(2'd2, d); chk("R7 cleared by rx off", d, 4'h0);
        pulse(3); tick();
        rd(2'd2, d); chk("R7 held while off", d, 4'h0);
        rd(2'd0, d); chk("R2 rx error still set", d, 4'h4);
        rx_enable = 1'b1; wr(2'd0, 4'h7);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_events();
        t_write_zero();
        t_collide();
        t_mask();
        t_irq();
        t_rx_off();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule